// File: doc/BRIEF.md
# Serial Control Port Register Slave

This block lets a host processor read and write a small internal byte-wide register file over a four-wire serial link. The link uses a mode-0 SPI-style scheme. It has an active-low chip-select, a serial clock that idles low, a data-in pin and a data-out pin. The data-out pin can be released to high impedance. The block samples input bits on rising serial-clock edges and changes output bits on falling edges.

Every access has exactly two bytes, framed by chip-select. The first byte is a command/address byte and the second is the data byte. The port is half-duplex. During a write the data-out pin carries nothing. During a read the data-in pin is ignored.

The serial pins are asynchronous to the block's system clock. They are synchronised and edge-detected inside the block, so the serial clock must run well below the system clock. An active-low power-down input releases the data-out pin and discards any access in progress. A byte-wide status input is sampled into a read-only status register.

Top module: `scp_reg_slave`

## Requirements
- R1: After reset, the writable registers hold these values: 00h and 01h hold 00h, 1Dh holds 08h and 24h holds 80h. The status register at 22h holds 00h while the status input is 00h.
- R2: Address 03h is a read-only revision register. It always returns 02h, and writes to it are ignored.
- R3: The command byte is sent MSB first. Bit 7 = 1 means read and bit 7 = 0 means write. Bits 6:0 are the register address. The data byte is also sent MSB first, and a byte written to a writable address reads back unchanged.
- R4: On a read, the MSB of the addressed register appears on the first serial-clock falling edge after the eighth command rising edge. Each later falling edge presents the next lower bit.
- R5: `sdo_oe` is high only during the data byte of a read. It is low when idle, during the command byte, during a write's data byte and after the data byte. While `sdo_oe` is low, `sdo` is high impedance.
- R6: While `pwrdn_n` is low, `sdo_oe` is low, any access in progress is dropped, and no register is written.
- R7: A write takes effect only once all eight data bits have been received. If chip-select rises earlier, no register changes.
- R8: Writes to read-only addresses (03h, 22h) and to unimplemented addresses are ignored. Reads of unimplemented addresses return 00h.
- R9: Reading address 22h returns the value present on `stat_in`.
- R10: Data-in bits are ignored during the data byte of a read and after the data byte of any access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrdn_n | input | 1 | Active-low power-down |
| cs_n | input | 1 | Active-low chip-select from the host |
| sclk | input | 1 | Serial clock from the host, idle low |
| sdi | input | 1 | Serial data from the host |
| stat_in | input | 8 | Status value exposed at address 22h |
| sdo | output | 1 | Serial data to the host, high impedance when not driven |
| sdo_oe | output | 1 | High while sdo is driven |

## Verification
The assertions assume that the host keeps chip-select, the serial clock and data-in stable for several system-clock cycles around each edge. They also assume that data-in changes only while the serial clock is low, so that the synchronised copies of these signals stay in the order the host intended. The bench drives every serial level for eight system-clock cycles. It changes data-in only after a falling serial-clock edge, and it lowers chip-select a full half-period before the first rising edge. Power-down is asserted only between system-clock edges and is held for many cycles, so the one-cycle-later checks on the output enable always see a settled input.

// File: rtl/scp_pkg.sv
package scp_pkg;
    localparam int DW = 8;
    localparam int AW = 7;
    localparam int CW = $clog2(DW);
    localparam int NUM_RW = 4;

    localparam logic [AW-1:0] ADDR_REV  = 7'h03;
    localparam logic [AW-1:0] ADDR_STAT = 7'h22;
    localparam logic [DW-1:0] REV_VALUE = 8'h02;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CMD,
        PH_DATA,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic          rd;
        logic [AW-1:0] addr;
    } cmd_t;

    function automatic logic [AW-1:0] rw_addr(input int idx);
        case (idx)
            0:       return 7'h00;
            1:       return 7'h01;
            2:       return 7'h1D;
            default: return 7'h24;
        endcase
    endfunction

    function automatic logic [DW-1:0] rw_reset(input int idx);
        case (idx)
            2:       return 8'h08;
            3:       return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic is_writable(input logic [AW-1:0] a);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < NUM_RW; i++) begin
            if (a == rw_addr(i)) hit = 1'b1;
        end
        return hit;
    endfunction
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= d;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/scp_engine.sv
module scp_engine
    import scp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          pwrdn_n,
    input  logic          s_cs_n,
    input  logic          s_sclk,
    input  logic          s_sdi,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          sdo_q,
    output logic          sdo_oe
);
    phase_e        phase;
    cmd_t          cmd;
    logic [CW-1:0] cnt;
    logic [DW-2:0] shreg;
    logic [DW-1:0] tx;
    logic          p_cs_n, p_sclk;
    logic          cs_fall, clk_rise, clk_fall;
    logic [DW-1:0] byte_in;

    assign cs_fall  = p_cs_n & ~s_cs_n;
    assign clk_rise = s_sclk & ~p_sclk & ~s_cs_n;
    assign clk_fall = ~s_sclk & p_sclk & ~s_cs_n;
    assign byte_in  = {shreg, s_sdi};
    assign rd_addr  = byte_in[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            p_cs_n <= 1'b1;
            p_sclk <= 1'b0;
        end else begin
            p_cs_n <= s_cs_n;
            p_sclk <= s_sclk;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !pwrdn_n) begin
            phase   <= PH_IDLE;
            cmd     <= '0;
            cnt     <= '0;
            shreg   <= '0;
            tx      <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            sdo_q   <= 1'b0;
            sdo_oe  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (s_cs_n) begin
                phase  <= PH_IDLE;
                sdo_oe <= 1'b0;
            end else if (cs_fall) begin
                phase <= PH_CMD;
                cnt   <= '0;
            end else if (clk_rise) begin
                case (phase)
                    PH_CMD: begin
                        shreg <= byte_in[DW-2:0];
                        cnt   <= cnt + 1'b1;
                        if (cnt == CW'(DW-1)) begin
                            cmd   <= byte_in;
                            phase <= PH_DATA;
                            if (byte_in[DW-1]) tx <= rd_data;
                        end
                    end
                    PH_DATA: begin
                        shreg <= byte_in[DW-2:0];
                        cnt   <= cnt + 1'b1;
                        if (cnt == CW'(DW-1)) begin
                            phase  <= PH_DONE;
                            sdo_oe <= 1'b0;
                            if (!cmd.rd && is_writable(cmd.addr)) begin
                                wr_en   <= 1'b1;
                                wr_addr <= cmd.addr;
                                wr_data <= byte_in;
                            end
                        end
                    end
                    default: ;
                endcase
            end else if (clk_fall && phase == PH_DATA && cmd.rd) begin
                sdo_q  <= tx[DW-1];
                tx     <= {tx[DW-2:0], 1'b0};
                sdo_oe <= 1'b1;
            end
        end
    end

    AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        sdo_oe |-> (phase == PH_DATA && cmd.rd)); // R5
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en); // R7
    AST_WR_AFTER_FULL_BYTE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (phase == PH_DONE && !cmd.rd)); // R7
    AST_PD_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !pwrdn_n |=> (!sdo_oe && !wr_en && phase == PH_IDLE)); // R6
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile
    import scp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] stat_in,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] rw_q [NUM_RW];
    logic [DW-1:0] stat_q;

    generate
        for (genvar i = 0; i < NUM_RW; i++) begin : g_rw
            always_ff @(posedge clk) begin
                if (rst) begin
                    rw_q[i] <= rw_reset(i);
                end else if (wr_en && wr_addr == rw_addr(i)) begin
                    rw_q[i] <= wr_data;
                end
            end

            AST_RST_VAL: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> rw_q[i] == rw_reset(i)); // R1
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_in;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_RW; i++) begin
            if (rd_addr == rw_addr(i)) rd_data = rw_q[i];
        end
        if (rd_addr == ADDR_REV)  rd_data = REV_VALUE;
        if (rd_addr == ADDR_STAT) rd_data = stat_q;
    end

    AST_NO_RO_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr != ADDR_REV && wr_addr != ADDR_STAT)); // R8
endmodule

// File: rtl/scp_reg_slave.sv
module scp_reg_slave
    import scp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwrdn_n,
    input  logic          cs_n,
    input  logic          sclk,
    input  logic          sdi,
    input  logic [DW-1:0] stat_in,
    output logic          sdo,
    output logic          sdo_oe
);
    logic [2:0]    sync_q;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] rd_data, wr_data;
    logic          wr_en, sdo_q;

    scp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, sclk, sdi}),
        .q   (sync_q)
    );

    scp_engine u_eng (
        .clk     (clk),
        .rst     (rst),
        .pwrdn_n (pwrdn_n),
        .s_cs_n  (sync_q[2]),
        .s_sclk  (sync_q[1]),
        .s_sdi   (sync_q[0]),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sdo_q   (sdo_q),
        .sdo_oe  (sdo_oe)
    );

    scp_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .stat_in (stat_in),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign sdo = sdo_oe ? sdo_q : 1'bz;

    AST_OE_IDLE_CS: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_oe); // R5
endmodule

// File: tb/sim_scp_reg_slave.sv
module sim_scp_reg_slave;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwrdn_n = 1'b1;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic [7:0] stat_in = 8'h00;
    logic       sdo, sdo_oe;

    int  total = 0;
    int  bad = 0;
    bit  finished = 0;
    bit  oe_bad;

    always #10 clk = ~clk;

    scp_reg_slave u0 (
        .clk(clk), .rst(rst), .pwrdn_n(pwrdn_n), .cs_n(cs_n), .sclk(sclk),
        .sdi(sdi), .stat_in(stat_in), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // nbits data bits are clocked; junk drives sdi high during read data / extra bits
    task automatic xfer(input logic rd, input logic [6:0] a, input logic [7:0] wd,
                        input int nbits, input logic junk, output logic [7:0] rdv);
        logic [7:0] c;
        c = {rd, a};
        rdv = 8'h00;
        oe_bad = 1'b0;
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 7; i >= 0; i--) begin
            sdi = c[i];
            wait_clk(HALF);
            if (sdo_oe) oe_bad = 1'b1;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        for (int i = 0; i < nbits; i++) begin
            if (rd || i >= 8) sdi = junk;
            else              sdi = wd[7-i];
            wait_clk(HALF);
            if (rd && i < 8) begin
                if (!sdo_oe) oe_bad = 1'b1;
                rdv[7-i] = sdo;
            end else if (sdo_oe) begin
                oe_bad = 1'b1;
            end
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        if (sdo_oe) oe_bad = 1'b1;
        cs_n = 1'b1;
        wait_clk(2*HALF);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] dummy;
        xfer(1'b0, a, d, 8, 1'b0, dummy);
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d);
        xfer(1'b1, a, 8'h00, 8, 1'b0, d);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check1("R5 idle oe after reset", sdo_oe, 1'b0);
        rd(7'h00, v); check8("R1 reg00 reset", v, 8'h00);
        rd(7'h01, v); check8("R1 reg01 reset", v, 8'h00);
        rd(7'h1D, v); check8("R1 reg1D reset", v, 8'h08);
        rd(7'h24, v); check8("R1 reg24 reset", v, 8'h80);
        rd(7'h22, v); check8("R1 status reset", v, 8'h00);
    endtask

    task automatic t_rev();
        logic [7:0] v;
        rd(7'h03, v); check8("R2 revision", v, 8'h02);
        wr(7'h03, 8'hFF);
        rd(7'h03, v); check8("R2 revision after write", v, 8'h02);
    endtask

    task automatic t_rw();
        logic [7:0] v;
        wr(7'h00, 8'hA5);
        wr(7'h01, 8'h5A);
        wr(7'h1D, 8'h81);
        wr(7'h24, 8'h3C);
        rd(7'h00, v); check8("R3 reg00 A5", v, 8'hA5);
        check1("R5 oe during read data", oe_bad, 1'b0);
        rd(7'h01, v); check8("R3 reg01 5A", v, 8'h5A);
        rd(7'h1D, v); check8("R3 R4 reg1D MSB-first 81", v, 8'h81);
        rd(7'h24, v); check8("R3 reg24 3C", v, 8'h3C);
        wr(7'h24, 8'h01);
        check1("R5 oe in write", oe_bad, 1'b0);
        rd(7'h24, v); check8("R4 reg24 LSB only", v, 8'h01);
    endtask

    task automatic t_ro_unimpl();
        logic [7:0] v;
        stat_in = 8'h00;
        wr(7'h22, 8'h55);
        rd(7'h22, v); check8("R8 status write ignored", v, 8'h00);
        wr(7'h10, 8'h77);
        rd(7'h10, v); check8("R8 unimplemented reads zero", v, 8'h00);
        rd(7'h7F, v); check8("R8 addr 7F reads zero", v, 8'h00);
        rd(7'h00, v); check8("R8 unimpl write leaves reg00", v, 8'hA5);
    endtask

    task automatic t_status();
        logic [7:0] v;
        stat_in = 8'hC3;
        wait_clk(4);
        rd(7'h22, v); check8("R9 status C3", v, 8'hC3);
        stat_in = 8'h1E;
        wait_clk(4);
        rd(7'h22, v); check8("R9 status 1E", v, 8'h1E);
    endtask

    task automatic t_abort();
        logic [7:0] v;
        xfer(1'b0, 7'h01, 8'hFF, 7, 1'b0, v);
        rd(7'h01, v); check8("R7 abort after 7 bits", v, 8'h5A);
        xfer(1'b0, 7'h01, 8'hFF, 0, 1'b0, v);
        rd(7'h01, v); check8("R7 abort after command", v, 8'h5A);
    endtask

    task automatic t_sdi_ignored();
        logic [7:0] v;
        xfer(1'b1, 7'h00, 8'h00, 8, 1'b1, v);
        check8("R10 read with sdi high", v, 8'hA5);
        rd(7'h00, v); check8("R10 reg00 unchanged by read", v, 8'hA5);
        xfer(1'b0, 7'h01, 8'h3C, 12, 1'b1, v);
        rd(7'h01, v); check8("R10 extra bits ignored", v, 8'h3C);
    endtask

    task automatic t_pwrdn();
        logic [7:0] v;
        // begin a read of 1Dh, assert power-down during data byte
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 7; i >= 0; i--) begin
            sdi = (8'h9D >> i) & 1;
            wait_clk(HALF); sclk = 1'b1; wait_clk(HALF); sclk = 1'b0;
        end
        wait_clk(HALF);
        check1("R4 oe up after command", sdo_oe, 1'b1);
        pwrdn_n = 1'b0;
        wait_clk(2);
        check1("R6 oe released in power-down", sdo_oe, 1'b0);
        cs_n = 1'b1;
        wait_clk(2*HALF);
        xfer(1'b0, 7'h00, 8'h11, 8, 1'b0, v);
        check1("R6 oe low during power-down", oe_bad, 1'b0);
        pwrdn_n = 1'b1;
        wait_clk(4);
        rd(7'h00, v); check8("R6 write in power-down ignored", v, 8'hA5);
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);
        t_reset();
        t_rev();
        t_rw();
        t_ro_unimpl();
        t_status();
        t_abort();
        t_sdi_ignored();
        t_pwrdn();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule